// File: doc/BRIEF.md
# Event Channel Source Multiplexer

This block feeds one event channel. An 8-bit select register picks one single-cycle strobe from a vector of peripheral event inputs and passes it to the channel output. A software strobe is OR'ed in after the selection, so it reaches the channel even when the select register routes nothing.

A per-peripheral presence mask marks which optional peripherals exist on the chip. A code that names an absent peripheral acts exactly like code 0. A channel-index parameter sets which bus-interface event code 0x0A picks, so identical instances give each channel its own source for that code. The output is registered and lags its inputs by one clock.

The source vector `src_i` is indexed as follows:
- bit 0: timer overflow
- bit 1: timer compare
- bits 2 to 5: bus-interface start-of-frame, error, overflow and setup
- bits 6 to 8: comparator A channel 0, channel 1 and window
- bit 9: comparator B channel 0

The presence mask `pres_i` is indexed as follows:
- bit 0: timer
- bit 1: bus interface
- bit 2: comparator A
- bit 3: comparator B

Top module: `evsel_chan`

## Requirements
- R1: While `rst_ni` is low and after reset, `sel_q_o` reads 0x00 and `chan_evt_o` is 0.
- R2: When `sel_we_i` is high at a rising edge, `sel_wdata_i` is stored, and `sel_q_o` shows it after that edge.
- R3: With select value 0x00, no peripheral strobe reaches `chan_evt_o`.
- R4: When `man_evt_i` is high at an edge, `chan_evt_o` is 1 for the following cycle. This holds for any select value and any presence mask.
- R5: Code 0x08 routes `src_i[0]` and code 0x09 routes `src_i[1]`. Both require `pres_i[0]`.
- R6: Code 0x10 routes `src_i[6]`, 0x11 routes `src_i[7]` and 0x12 routes `src_i[8]`, all three requiring `pres_i[2]`. Code 0x13 routes `src_i[9]` and requires `pres_i[3]`.
- R7: Code 0x0A routes `src_i[2+CHAN_IDX]` and requires `pres_i[1]`. The other bus-interface strobes have no effect on that channel.
- R8: A code whose peripheral's presence bit is 0 routes nothing, the same as code 0x00.
- R9: Codes 0x01 to 0x07, 0x0B to 0x0F and 0x14 to 0xFF route no peripheral strobe.
- R10: `chan_evt_o` is a registered copy of the routed strobe OR `man_evt_i`. It is high for exactly the cycles after edges where that OR was high.
- R11: A select write applies from the next edge. At the edge that performs the write, routing still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_we_i | input | 1 | Select register write enable |
| sel_wdata_i | input | 8 | Select register write data |
| sel_q_o | output | 8 | Select register read value |
| src_i | input | 10 | Peripheral event strobes |
| pres_i | input | 4 | Peripheral presence mask |
| man_evt_i | input | 1 | Manual event strobe |
| chan_evt_o | output | 1 | Channel event output |

## Verification
The bench builds two instances side by side, one with `CHAN_IDX` = 0 and one with `CHAN_IDX` = 3. Both see the same stimulus, so a single 0x0A selection must raise one instance and not the other when only start-of-frame or only setup pulses. Using the lowest and highest channel index also exposes an off-by-one in how the channel number picks its bus-interface strobe. The remaining codes, the presence gating and the write-cycle timing are compared on both instances at once.

// File: rtl/evsel_pkg.sv
package evsel_pkg;
  localparam int SEL_W      = 8;
  localparam int NUM_SRC    = 10;
  localparam int NUM_PERIPH = 4;
  localparam int NUM_BUS_EVT = 4;

  // source vector positions
  localparam int SRC_TK_OVF = 0;
  localparam int SRC_TK_CMP = 1;
  localparam int SRC_BUS0   = 2;
  localparam int SRC_CA_CH0 = 6;
  localparam int SRC_CA_CH1 = 7;
  localparam int SRC_CA_WIN = 8;
  localparam int SRC_CB_CH0 = 9;

  // presence mask positions
  localparam int P_TK  = 0;
  localparam int P_BUS = 1;
  localparam int P_CA  = 2;
  localparam int P_CB  = 3;

  // select codes
  localparam logic [SEL_W-1:0] CODE_NONE   = 8'h00;
  localparam logic [SEL_W-1:0] CODE_TK_OVF = 8'h08;
  localparam logic [SEL_W-1:0] CODE_TK_CMP = 8'h09;
  localparam logic [SEL_W-1:0] CODE_BUS    = 8'h0A;
  localparam logic [SEL_W-1:0] CODE_CA_CH0 = 8'h10;
  localparam logic [SEL_W-1:0] CODE_CA_CH1 = 8'h11;
  localparam logic [SEL_W-1:0] CODE_CA_WIN = 8'h12;
  localparam logic [SEL_W-1:0] CODE_CB_CH0 = 8'h13;
endpackage

// File: rtl/evsel_reg.sv
module evsel_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/evsel_decode.sv
module evsel_decode
  import evsel_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM_PERIPH-1:0] pres_i,
  output logic [NUM_SRC-1:0]    route_o
);
  logic bus_hit;
  logic [NUM_BUS_EVT-1:0] bus_route;

  // channel index picks which bus strobe code 0x0A carries
  generate
    if (CHAN_IDX >= 0 && CHAN_IDX < NUM_BUS_EVT) begin : g_bus
      assign bus_hit = (sel_i == CODE_BUS) && pres_i[P_BUS];
    end else begin : g_nobus
      assign bus_hit = 1'b0;
    end
    for (genvar k = 0; k < NUM_BUS_EVT; k++) begin : g_bus_lane
      assign bus_route[k] = bus_hit && (k == CHAN_IDX);
    end
  endgenerate

  always_comb begin
    route_o = '0;
    route_o[SRC_TK_OVF] = (sel_i == CODE_TK_OVF) && pres_i[P_TK];
    route_o[SRC_TK_CMP] = (sel_i == CODE_TK_CMP) && pres_i[P_TK];
    route_o[SRC_CA_CH0] = (sel_i == CODE_CA_CH0) && pres_i[P_CA];
    route_o[SRC_CA_CH1] = (sel_i == CODE_CA_CH1) && pres_i[P_CA];
    route_o[SRC_CA_WIN] = (sel_i == CODE_CA_WIN) && pres_i[P_CA];
    route_o[SRC_CB_CH0] = (sel_i == CODE_CB_CH0) && pres_i[P_CB];
    route_o[SRC_BUS0 +: NUM_BUS_EVT] = bus_route;
  end
endmodule

// File: rtl/evsel_out.sv
module evsel_out #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] route_i,
  input  logic [N-1:0] src_i,
  input  logic         man_i,
  output logic         evt_o
);
  logic hit;
  assign hit = man_i | (|(route_i & src_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= 1'b0;
    else         evt_o <= hit;
  end
endmodule

// File: rtl/evsel_chan.sv
module evsel_chan
  import evsel_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_we_i,
  input  logic [SEL_W-1:0]      sel_wdata_i,
  output logic [SEL_W-1:0]      sel_q_o,
  input  logic [NUM_SRC-1:0]    src_i,
  input  logic [NUM_PERIPH-1:0] pres_i,
  input  logic                  man_evt_i,
  output logic                  chan_evt_o
);
  logic [NUM_SRC-1:0] route;

  evsel_reg #(.W(SEL_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (sel_we_i),
    .wdata_i (sel_wdata_i),
    .q_o     (sel_q_o)
  );

  evsel_decode #(.CHAN_IDX(CHAN_IDX)) u_dec (
    .sel_i   (sel_q_o),
    .pres_i  (pres_i),
    .route_o (route)
  );

  evsel_out #(.N(NUM_SRC)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .route_i (route),
    .src_i   (src_i),
    .man_i   (man_evt_i),
    .evt_o   (chan_evt_o)
  );
endmodule

// File: rtl/evsel_chan_chk.sv
module evsel_chan_chk
  import evsel_pkg::*;
#(
  parameter int CHAN_IDX = 0
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  sel_we_i,
  input logic [SEL_W-1:0]      sel_wdata_i,
  input logic [SEL_W-1:0]      sel_q_o,
  input logic [NUM_SRC-1:0]    src_i,
  input logic [NUM_PERIPH-1:0] pres_i,
  input logic                  man_evt_i,
  input logic                  chan_evt_o,
  input logic [NUM_SRC-1:0]    route_i
);
  logic reserved;
  assign reserved = (sel_q_o inside {[8'h01:8'h07], [8'h0B:8'h0F]}) || (sel_q_o > 8'h13);

  p_reset_state_r1: assert property (@(posedge clk_i) !rst_ni |-> (sel_q_o == '0 && !chan_evt_o));

  p_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_we_i |=> sel_q_o == $past(sel_wdata_i));

  p_code0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_o == CODE_NONE && !man_evt_i) |=> !chan_evt_o);

  p_manual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_evt_i |=> chan_evt_o);

  p_timer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_o == CODE_TK_OVF && pres_i[P_TK] && src_i[SRC_TK_OVF]) |=> chan_evt_o);

  p_cmp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q_o == CODE_CB_CH0 && pres_i[P_CB] && src_i[SRC_CB_CH0]) |=> chan_evt_o);

  generate
    if (CHAN_IDX >= 0 && CHAN_IDX < NUM_BUS_EVT) begin : g_bus_chk
      p_bus_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_q_o == CODE_BUS && pres_i[P_BUS] && src_i[SRC_BUS0+CHAN_IDX]) |=> chan_evt_o);
    end
  endgenerate

  p_absent_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!man_evt_i && !pres_i[P_TK] && (sel_q_o == CODE_TK_OVF || sel_q_o == CODE_TK_CMP)) |=> !chan_evt_o);

  p_reserved_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reserved && !man_evt_i) |=> !chan_evt_o);

  p_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!man_evt_i && src_i == '0) |=> !chan_evt_o);

  p_route_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(route_i));
endmodule

bind evsel_chan evsel_chan_chk #(.CHAN_IDX(CHAN_IDX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_we_i    (sel_we_i),
  .sel_wdata_i (sel_wdata_i),
  .sel_q_o     (sel_q_o),
  .src_i       (src_i),
  .pres_i      (pres_i),
  .man_evt_i   (man_evt_i),
  .chan_evt_o  (chan_evt_o),
  .route_i     (route)
);

// File: tb/tb_evsel_chan.sv
module tb_evsel_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [9:0] src = '0;
  logic [3:0] pres = '0;
  logic       man = 1'b0;
  logic [7:0] q0, q3;
  logic       e0, e3;

  int checks = 0;
  int errors = 0;
  logic [7:0] sel_model = '0;
  bit done = 0;

  typedef struct { bit x0; bit x3; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  evsel_chan #(.CHAN_IDX(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(we), .sel_wdata_i(wdata), .sel_q_o(q0),
    .src_i(src), .pres_i(pres), .man_evt_i(man), .chan_evt_o(e0));

  evsel_chan #(.CHAN_IDX(3)) dut3 (
    .clk_i(clk), .rst_ni(rst_n), .sel_we_i(we), .sel_wdata_i(wdata), .sel_q_o(q3),
    .src_i(src), .pres_i(pres), .man_evt_i(man), .chan_evt_o(e3));

  function automatic bit model(int ch, logic [7:0] s, logic [9:0] v, logic [3:0] p, bit m);
    bit r;
    case (s)
      8'h08: r = v[0] & p[0];
      8'h09: r = v[1] & p[0];
      8'h0A: r = v[2+ch] & p[1];
      8'h10: r = v[6] & p[2];
      8'h11: r = v[7] & p[2];
      8'h12: r = v[8] & p[2];
      8'h13: r = v[9] & p[3];
      default: r = 1'b0;
    endcase
    return r | m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // driver: one cycle of stimulus, expected result queued for the monitor
  task automatic step(bit w, logic [7:0] d, logic [9:0] v, logic [3:0] p, bit m, string tag);
    exp_t it;
    @(negedge clk);
    we = w; wdata = d; src = v; pres = p; man = m;
    it.x0 = model(0, sel_model, v, p, m);
    it.x3 = model(3, sel_model, v, p, m);
    it.tag = tag;
    sb.push_back(it);
    if (w) sel_model = d;
    @(posedge clk);
  endtask

  task automatic readback(string tag);
    @(negedge clk);
    we = 0; src = '0; man = 0;
    check({tag, " sel readback ch0"}, 32'(q0), 32'(sel_model));
    check({tag, " sel readback ch3"}, 32'(q3), 32'(sel_model));
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        check({it.tag, " ch0 evt"}, 32'(e0), 32'(it.x0));
        check({it.tag, " ch3 evt"}, 32'(e3), 32'(it.x3));
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rsv [$];
    #12;
    check("R1 reset sel", 32'(q0), 32'h0);
    check("R1 reset evt", 32'({e0, e3}), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    readback("R1");

    step(0, 8'h00, 10'h3FF, 4'hF, 0, "R3 code0 all src");
    step(0, 8'h00, 10'h000, 4'hF, 1, "R4 manual code0");
    step(0, 8'h00, 10'h000, 4'hF, 0, "R10 pulse ends");

    step(1, 8'h08, 10'h001, 4'hF, 0, "R11 write cycle old sel");
    readback("R2");
    step(0, 8'h00, 10'h001, 4'hF, 0, "R5 timer ovf");
    step(0, 8'h00, 10'h000, 4'hF, 0, "R10 single pulse");
    step(0, 8'h00, 10'h002, 4'hF, 0, "R5 cmp ignored on ovf");
    step(0, 8'h00, 10'h001, 4'hF, 0, "R10 back to back a");
    step(0, 8'h00, 10'h001, 4'hF, 0, "R10 back to back b");

    step(1, 8'h09, 10'h003, 4'hF, 0, "R11 switch uses old");
    step(0, 8'h00, 10'h001, 4'hF, 0, "R11 new sel ignores ovf");
    step(0, 8'h00, 10'h002, 4'hF, 0, "R5 timer cmp");

    step(1, 8'h0A, 10'h000, 4'hF, 0, "R2 write 0A");
    step(0, 8'h00, 10'h004, 4'hF, 0, "R7 sof");
    step(0, 8'h00, 10'h020, 4'hF, 0, "R7 setup");
    step(0, 8'h00, 10'h018, 4'hF, 0, "R7 err ovf");
    step(0, 8'h00, 10'h03C, 4'hD, 0, "R8 bus absent");

    for (int c = 16; c <= 19; c++) begin
      step(1, 8'(c), 10'h000, 4'hF, 0, "R2 write cmp");
      step(0, 8'h00, 10'(1 << (c - 10)), 4'hF, 0, "R6 comparator src");
      step(0, 8'h00, 10'h03F, 4'hF, 0, "R6 other src ignored");
    end
    step(0, 8'h00, 10'h200, 4'h7, 0, "R8 cmp B absent");
    step(0, 8'h00, 10'h200, 4'h0, 1, "R4 manual absent");

    step(1, 8'h08, 10'h000, 4'hF, 0, "R2 write 08");
    step(0, 8'h00, 10'h3FF, 4'hE, 0, "R8 timer absent");
    step(0, 8'h00, 10'h3FF, 4'hE, 1, "R4 manual overrides");

    rsv = '{8'h01, 8'h04, 8'h07, 8'h0B, 8'h0F, 8'h14, 8'h80, 8'hFF};
    foreach (rsv[i]) begin
      step(1, rsv[i], 10'h000, 4'hF, 0, "R2 write reserved");
      step(0, 8'h00, 10'h3FF, 4'hF, 0, "R9 reserved routes nothing");
    end
    readback("R2");
    step(0, 8'h00, 10'h3FF, 4'hF, 1, "R4 manual reserved");
    step(0, 8'h00, 10'h000, 4'h0, 0, "R10 idle");
    @(negedge clk);
    we = 0; src = '0; man = 0;
    repeat (2) @(posedge clk);
    #3;
    check("scoreboard drained", 32'(sb.size()), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule